// File: doc/BRIEF.md
# Converter Threshold Interrupt with Shared Request Line

This block watches the sample buffer occupancy of a data converter and raises a converter interrupt once the buffer holds at least a programmed number of samples. The interrupt is kept in a pending flag that software can read as a status bit. Software clears it either by writing one to a clear strobe or by turning off the interrupt enable.

The pending converter interrupt is merged with two other interrupt sources onto one active-high request line. The line stays high as long as any of the three sources is requesting. Clearing one source therefore does not necessarily drop the line.

The pending flag is edge-qualified. It sets on the clock edge where the comparison first becomes true. After a clear, it sets again only when the comparison goes false and then true again. This keeps a buffer that stays above threshold from re-raising the interrupt straight after service.

Top module: `adc_thresh_irq`

## Requirements
- R1: With the enable high, the first clock edge at which the occupancy is equal to or greater than the threshold, while the previous cycle's comparison was false, sets the pending flag, visible after that edge.
- R2: While the enable is low the threshold is ignored: the pending flag never sets, and an edge with the enable low clears a flag that was set.
- R3: An edge where the clear strobe is high clears the pending flag.
- R4: If a set condition (R1) and the clear strobe occur in the same cycle, the flag is clear after that edge.
- R5: After a clear, the flag stays clear while the comparison remains true. It sets again only after the comparison goes false and then true again.
- R6: The request line is high whenever the pending flag or either external source is high. It is low only when all three are low, and the external sources pass through combinationally.
- R7: An active-low reset clears the pending flag and the stored comparison history.
- R8: Threshold comparison is unsigned over the full count width: a threshold of 0 sets the flag on enabling, and the full-scale value sets it only at full-scale occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occupancy | input | CNT_W | Current number of samples in the buffer |
| threshold | input | CNT_W | Programmed interrupt threshold |
| int_en | input | 1 | Converter interrupt enable |
| clr_wr | input | 1 | One-cycle write-one clear of the pending flag |
| ext_a | input | 1 | First external interrupt source request |
| ext_b | input | 1 | Second external interrupt source request |
| pend_stat | output | 1 | Converter interrupt pending status |
| irq | output | 1 | Combined active-high interrupt request line |

## Verification
The bench builds the block with a count width of 4 rather than the default 12. This makes the full-scale occupancy of 15 reachable in a handful of vectors, alongside a zero threshold. It can then walk the comparator's both extremes, exact-equality hits and the clear-versus-set collision in one short table. It also checks that the line stays high while the converter flag is cleared but an external source still requests.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;

  localparam int NUM_SRC = 3;

  // Clear has priority over set; otherwise the flag holds.
  function automatic logic next_pend(input logic cur, input logic set, input logic clr);
    if (clr)      return 1'b0;
    else if (set) return 1'b1;
    else          return cur;
  endfunction

endpackage

// File: rtl/adc_irq_cmp.sv
module adc_irq_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] threshold,
  input  logic             enable,
  output logic             hit,
  output logic             rise
);

  function automatic logic reached(input logic [CNT_W-1:0] occ, input logic [CNT_W-1:0] thr);
    return occ >= thr;
  endfunction

  logic hit_q;

  assign hit  = enable && reached(occupancy, threshold);
  assign rise = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

endmodule

// File: rtl/adc_irq_latch.sv
module adc_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_wr,
  input  logic enable,
  output logic pend
);

  logic clr_any;

  assign clr_any = clr_wr || !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= adc_irq_pkg::next_pend(pend, set, clr_any);
  end

endmodule

// File: rtl/adc_irq_merge.sv
module adc_irq_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic         line
);

  assign line = |req;

endmodule

// File: rtl/adc_thresh_irq.sv
module adc_thresh_irq #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] threshold,
  input  logic             int_en,
  input  logic             clr_wr,
  input  logic             ext_a,
  input  logic             ext_b,
  output logic             pend_stat,
  output logic             irq
);

  localparam int NSRC = adc_irq_pkg::NUM_SRC;

  logic            cmp_hit;
  logic            cmp_rise;
  logic            conv_pend;
  logic [NSRC-1:0] src_vec;

  adc_irq_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .occupancy(occupancy),
    .threshold(threshold),
    .enable   (int_en),
    .hit      (cmp_hit),
    .rise     (cmp_rise)
  );

  adc_irq_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (cmp_rise),
    .clr_wr(clr_wr),
    .enable(int_en),
    .pend  (conv_pend)
  );

  assign src_vec = {ext_b, ext_a, conv_pend};

  adc_irq_merge #(.N(NSRC)) u_merge (
    .req (src_vec),
    .line(irq)
  );

  assign pend_stat = conv_pend;

endmodule

// File: rtl/adc_thresh_irq_chk.sv
module adc_thresh_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic int_en,
  input logic clr_wr,
  input logic ext_a,
  input logic ext_b,
  input logic cmp_hit,
  input logic cmp_rise,
  input logic pend,
  input logic irq
);

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_rise && !clr_wr) |=> pend); // R1

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |=> !pend); // R2

  AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !pend); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && cmp_rise) |=> !pend); // R4

  AST_NO_SET_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !cmp_rise) |=> !pend); // R5

  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_rise |-> cmp_hit); // R1

  AST_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pend || ext_a || ext_b) |-> irq); // R6

  AST_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (!pend && !ext_a && !ext_b)); // R6

endmodule

bind adc_thresh_irq adc_thresh_irq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .int_en  (int_en),
  .clr_wr  (clr_wr),
  .ext_a   (ext_a),
  .ext_b   (ext_b),
  .cmp_hit (cmp_hit),
  .cmp_rise(cmp_rise),
  .pend    (conv_pend),
  .irq     (irq)
);

// File: tb/adc_thresh_irq_tb.sv
module adc_thresh_irq_tb;

  localparam int W = 4;
  localparam int NV = 23;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] occupancy = '0;
  logic [W-1:0] threshold = '0;
  logic         int_en = 1'b0;
  logic         clr_wr = 1'b0;
  logic         ext_a = 1'b0;
  logic         ext_b = 1'b0;
  logic         pend_stat;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_thresh_irq #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .threshold(threshold),
    .int_en(int_en), .clr_wr(clr_wr), .ext_a(ext_a), .ext_b(ext_b),
    .pend_stat(pend_stat), .irq(irq)
  );

  // {occ, thr, en, clr, a, b, exp_pend, exp_irq}
  localparam logic [13:0] VEC [NV] = '{
    {4'd2, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 0  below threshold R1
    {4'd5, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1}, // 1  equal sets R1
    {4'd6, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1}, // 2  holds R1
    {4'd6, 4'd5, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0}, // 3  clear R3
    {4'd7, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 4  no re-set R5
    {4'd3, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 5  compare falls R5
    {4'd9, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1}, // 6  new rise R5
    {4'd9, 4'd5, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 7  disable clears R2
    {4'd9, 4'd5, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 8  ignored R2
    {4'd9, 4'd5, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1}, // 9  re-enable sets R1
    {4'd9, 4'd5, 1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1}, // 10 ext_a holds line R6
    {4'd9, 4'd5, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1}, // 11 ext_b holds line R6
    {4'd9, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 12 all idle R6
    {4'd4, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 13 below R4
    {4'd5, 4'd5, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0}, // 14 set+clear R4
    {4'd5, 4'd5, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 15 no re-set R5
    {4'd0, 4'd15,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 16 below max R8
    {4'd15,4'd15,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1}, // 17 full scale R8
    {4'd15,4'd15,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0}, // 18 clear R3
    {4'd0, 4'd0, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 19 still true R5
    {4'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // 20 disable R2
    {4'd0, 4'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1}, // 21 zero threshold R8
    {4'd0, 4'd0, 1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1}  // 22 all sources R6
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 9:             return "R1";
      7, 8, 20:               return "R2";
      3, 18:                  return "R3";
      13, 14:                 return "R4";
      4, 5, 6, 15, 19:        return "R5";
      10, 11, 12, 22:         return "R6";
      default:                return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7", "pend in reset", pend_stat, 1'b0);
    check("R7", "irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {occupancy, threshold, int_en, clr_wr, ext_a, ext_b} = VEC[i][13:2];
      @(posedge clk);
      #1;
      check(vec_tag(i), $sformatf("vec %0d pend", i), pend_stat, VEC[i][1]);
      check(vec_tag(i), $sformatf("vec %0d irq", i), irq, VEC[i][0]);
      @(negedge clk);
    end

    // R6: external sources pass through without a clock edge
    ext_a = 1'b0; ext_b = 1'b0; int_en = 1'b0; clr_wr = 1'b0;
    @(posedge clk); #1;
    check("R6", "idle line", irq, 1'b0);
    ext_b = 1'b1; #1;
    check("R6", "comb ext_b", irq, 1'b1);
    ext_b = 1'b0; #1;

    // R7: reset clears a set flag and the stored compare history
    occupancy = 4'd8; threshold = 4'd3; int_en = 1'b1;
    @(posedge clk); #1;
    check("R1", "set before reset", pend_stat, 1'b1);
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R7", "async reset pend", pend_stat, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R7", "history cleared, rise after reset", pend_stat, 1'b1);
    @(negedge clk);

    finish_run();
  end

endmodule